// File: doc/BRIEF.md
# Host Byte-Lane Steering for a Paired-Device Linear Flash Card

This block sits between the 16-bit host bus of a removable linear flash card and an array of flash device pairs. Each pair holds one 8-bit device on the low lane and one on the high lane. The block works out what each host access needs from the strobes: the two active-low lane enables, the address bit 0 and the output and write strobes. The active-low attribute-space select and the write-lock input also take part.

From that decision the block drives three sets of outputs:
- separate read and write enables for the low and the high device;
- a one-hot active-low select for the pair addressed by the upper address bits;
- a select toward the attribute store, which holds the card registers and the card information structure.

Read bytes are steered onto the host bus. When an 8-bit host reads at an odd address, the high device's byte moves onto the low lane. Write bytes are steered the other way. The host bus is a separate input, output and per-lane output-enable set.

Attribute reads return only even bytes. A lane or an address that carries no valid attribute byte reads as 8'hFF. Host strobes are assumed to be synchronised to `clk` upstream. Every control output is registered once. Host read data follows the device data combinationally, through the registered steering choice.

Top module: `lane_steer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, all device enables, pair selects and `attr_sel_n` are high. Both host lane enables are low, and `dev_addr` is zero.
- R2: With `en_even_n` and `en_odd_n` both high (standby), no host lane is driven, and no device enable, pair select or attribute select is asserted.
- R3: A common-memory read with both lane enables low is a word read, and `host_addr[0]` is ignored. The high device byte appears on `host_d_out[15:8]` and the low device byte on `host_d_out[7:0]`. Both lanes are driven and both device read enables are asserted.
- R4: A read with only `en_even_n` low is a byte read on `host_d_out[7:0]`, and `host_d_out[15:8]` is not driven. With `host_addr[0]`=0 only the low device is read and its byte is returned. With `host_addr[0]`=1 only the high device is read and its byte is returned on the low lane.
- R5: A read with only `en_odd_n` low reads only the high device and returns its byte on `host_d_out[15:8]`. The low lane is not driven.
- R6: A write is a cycle with `wr_strb_n` low and `rd_strb_n` high. It asserts write enables only toward the devices that the matching read would address. `lo_wdata` takes `host_d_in[7:0]`. `hi_wdata` takes `host_d_in[7:0]` for a byte write (only `en_even_n` low) and `host_d_in[15:8]` otherwise. A read and a write enable are never asserted together on a lane.
- R7: While `wr_lock` is high, no device write enable and no pair select is produced for a write. Attribute writes still assert `attr_sel_n`.
- R8: With `rd_strb_n` and `wr_strb_n` both low, or both high, no device enable, pair select, attribute select or host lane enable is asserted.
- R9: The pair index is `host_addr[ADDR_W-1:PAIR_LOG2]`. Only pair index i drives `pair_cs_n[i]` low, and only while a device enable is asserted. An index at or above `NUM_PAIRS` asserts no select and no device enable, and a read there returns 8'hFF on every driven lane.
- R10: With `attr_space_n` low, an access asserts `attr_sel_n` and no device enable or pair select. The lanes read as follows:
  - `host_d_out[7:0]` returns `attr_rdata` for a word read and for a byte read at `host_addr[0]`=0;
  - the low lane of a byte read at `host_addr[0]`=1 returns 8'hFF;
  - the high lane returns 8'hFF whenever it is driven.
- R11: Control outputs and write data reflect the inputs sampled at the previous rising clock edge. `host_d_out` follows the device and attribute read data in the same cycle.
- R12: `dev_addr` loads `host_addr[PAIR_LOG2-1:1]` on every read or write cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address; bit 0 selects the byte in a byte access |
| en_even_n | input | 1 | Active-low even-byte lane enable |
| en_odd_n | input | 1 | Active-low odd-byte lane enable |
| rd_strb_n | input | 1 | Active-low read strobe |
| wr_strb_n | input | 1 | Active-low write strobe |
| attr_space_n | input | 1 | Active-low attribute-space select |
| wr_lock | input | 1 | High blocks flash array writes |
| host_d_in | input | 16 | Data from the host |
| host_d_out | output | 16 | Data to the host |
| host_oe_lo | output | 1 | Host drives `host_d_out[7:0]` |
| host_oe_hi | output | 1 | Host drives `host_d_out[15:8]` |
| pair_cs_n | output | NUM_PAIRS | Active-low device pair selects |
| dev_addr | output | PAIR_LOG2-1 | Word address inside a pair |
| lo_rden_n | output | 1 | Low device read enable |
| lo_wren_n | output | 1 | Low device write enable |
| hi_rden_n | output | 1 | High device read enable |
| hi_wren_n | output | 1 | High device write enable |
| lo_wdata | output | 8 | Write byte to the low device |
| hi_wdata | output | 8 | Write byte to the high device |
| lo_rdata | input | 8 | Read byte from the low device |
| hi_rdata | input | 8 | Read byte from the high device |
| attr_sel_n | output | 1 | Active-low attribute store select |
| attr_rdata | input | 8 | Read byte from the attribute store |

## Verification
The bench builds the block with a 12-bit address, 256-byte pairs and three populated pairs. This leaves thirteen unpopulated pair slots, so out-of-range accesses of R9 are as easy to reach as in-range ones. The small address space also lets random addresses exercise every pair index and both values of the byte bit. Directed vectors then walk every combination of lane enables, strobes, space and write lock.

// File: rtl/lsteer_pkg.sv
package lsteer_pkg;

  typedef enum logic [1:0] {
    SRC_LO   = 2'd0,
    SRC_HI   = 2'd1,
    SRC_ATTR = 2'd2,
    SRC_FF   = 2'd3
  } lane_src_e;

  typedef struct packed {
    logic      lo_rd;
    logic      lo_wr;
    logic      hi_rd;
    logic      hi_wr;
    logic      attr;
    logic      drv_lo;
    logic      drv_hi;
    lane_src_e src_lo;
    lane_src_e src_hi;
    logic      xfer;
    logic      wr_cyc;
    logic      narrow;
  } steer_t;

  localparam steer_t STEER_IDLE = '{
    lo_rd: 1'b0, lo_wr: 1'b0, hi_rd: 1'b0, hi_wr: 1'b0, attr: 1'b0,
    drv_lo: 1'b0, drv_hi: 1'b0, src_lo: SRC_FF, src_hi: SRC_FF,
    xfer: 1'b0, wr_cyc: 1'b0, narrow: 1'b0
  };

endpackage

// File: rtl/lsteer_strobe_dec.sv
module lsteer_strobe_dec
  import lsteer_pkg::*;
(
  input  logic   en_even_n,
  input  logic   en_odd_n,
  input  logic   byte_hi,
  input  logic   rd_strb_n,
  input  logic   wr_strb_n,
  input  logic   attr_space_n,
  input  logic   wr_lock,
  input  logic   in_range,
  output steer_t steer
);

  logic any_en, rd, wr, word, narrow, odd_only, want_lo, want_hi, flash;

  always_comb begin
    any_en   = ~en_even_n | ~en_odd_n;
    rd       = any_en & ~rd_strb_n & wr_strb_n;
    wr       = any_en & ~wr_strb_n & rd_strb_n;
    word     = ~en_even_n & ~en_odd_n;
    narrow   = ~en_even_n & en_odd_n;
    odd_only = en_even_n & ~en_odd_n;
    want_lo  = word | (narrow & ~byte_hi);
    want_hi  = word | (narrow & byte_hi) | odd_only;
    flash    = attr_space_n & in_range;

    steer        = STEER_IDLE;
    steer.lo_rd  = rd & flash & want_lo;
    steer.hi_rd  = rd & flash & want_hi;
    steer.lo_wr  = wr & flash & want_lo & ~wr_lock;
    steer.hi_wr  = wr & flash & want_hi & ~wr_lock;
    steer.attr   = ~attr_space_n & (rd | wr);
    steer.drv_lo = rd & ~en_even_n;
    steer.drv_hi = rd & ~en_odd_n;
    steer.xfer   = rd | wr;
    steer.wr_cyc = wr;
    steer.narrow = narrow;

    if (!attr_space_n) begin
      steer.src_lo = (narrow & byte_hi) ? SRC_FF : SRC_ATTR;
      steer.src_hi = SRC_FF;
    end else if (!in_range) begin
      steer.src_lo = SRC_FF;
      steer.src_hi = SRC_FF;
    end else begin
      steer.src_lo = (narrow & byte_hi) ? SRC_HI : SRC_LO;
      steer.src_hi = SRC_HI;
    end
  end

endmodule

// File: rtl/lsteer_pair_sel.sv
module lsteer_pair_sel #(
  parameter int ADDR_W    = 26,
  parameter int PAIR_LOG2 = 21,
  parameter int NUM_PAIRS = 10
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PAIRS-1:0] hit,
  output logic                 in_range
);

  localparam int IDX_W = ADDR_W - PAIR_LOG2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:PAIR_LOG2];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign hit[p] = (idx == IDX_W'(p));
  end

  assign in_range = |hit;

endmodule

// File: rtl/lsteer_data_route.sv
module lsteer_data_route
  import lsteer_pkg::*;
(
  input  lane_src_e   src_lo,
  input  lane_src_e   src_hi,
  input  logic        drv_lo,
  input  logic        drv_hi,
  input  logic [7:0]  lo_rdata,
  input  logic [7:0]  hi_rdata,
  input  logic [7:0]  attr_rdata,
  input  logic        narrow,
  input  logic [15:0] host_d_in,
  output logic [15:0] host_d_out,
  output logic [7:0]  wd_lo,
  output logic [7:0]  wd_hi
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    lane_src_e  sel;
    logic       drv;
    logic [7:0] byte_v;
    assign sel = (g == 0) ? src_lo : src_hi;
    assign drv = (g == 0) ? drv_lo : drv_hi;
    always_comb begin
      case (sel)
        SRC_LO:   byte_v = lo_rdata;
        SRC_HI:   byte_v = hi_rdata;
        SRC_ATTR: byte_v = attr_rdata;
        default:  byte_v = 8'hFF;
      endcase
    end
    assign host_d_out[g*8 +: 8] = drv ? byte_v : 8'h00;
  end

  assign wd_lo = host_d_in[7:0];
  assign wd_hi = narrow ? host_d_in[7:0] : host_d_in[15:8];

endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lsteer_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int PAIR_LOG2 = 21,
  parameter int NUM_PAIRS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic                   en_even_n,
  input  logic                   en_odd_n,
  input  logic                   rd_strb_n,
  input  logic                   wr_strb_n,
  input  logic                   attr_space_n,
  input  logic                   wr_lock,
  input  logic [15:0]            host_d_in,
  output logic [15:0]            host_d_out,
  output logic                   host_oe_lo,
  output logic                   host_oe_hi,
  output logic [NUM_PAIRS-1:0]   pair_cs_n,
  output logic [PAIR_LOG2-2:0]   dev_addr,
  output logic                   lo_rden_n,
  output logic                   lo_wren_n,
  output logic                   hi_rden_n,
  output logic                   hi_wren_n,
  output logic [7:0]             lo_wdata,
  output logic [7:0]             hi_wdata,
  input  logic [7:0]             lo_rdata,
  input  logic [7:0]             hi_rdata,
  output logic                   attr_sel_n,
  input  logic [7:0]             attr_rdata
);

  localparam int DA_W = PAIR_LOG2 - 1;

  steer_t               steer_w, steer_d, steer_q;
  logic [NUM_PAIRS-1:0] hit_w, cs_n_d, cs_n_q;
  logic                 in_range_w, dev_any;
  logic [DA_W-1:0]      addr_d, addr_q;
  logic [7:0]           wd_lo_w, wd_hi_w, wd_lo_d, wd_hi_d, wd_lo_q, wd_hi_q;
  logic [15:0]          unused_d;

  lsteer_pair_sel #(
    .ADDR_W(ADDR_W), .PAIR_LOG2(PAIR_LOG2), .NUM_PAIRS(NUM_PAIRS)
  ) u_pair_sel (
    .addr(host_addr), .hit(hit_w), .in_range(in_range_w)
  );

  lsteer_strobe_dec u_dec (
    .en_even_n(en_even_n), .en_odd_n(en_odd_n), .byte_hi(host_addr[0]),
    .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
    .attr_space_n(attr_space_n), .wr_lock(wr_lock),
    .in_range(in_range_w), .steer(steer_w)
  );

  // write path uses the live decode; read path uses the registered one
  lsteer_data_route u_wr_route (
    .src_lo(steer_w.src_lo), .src_hi(steer_w.src_hi),
    .drv_lo(1'b0), .drv_hi(1'b0),
    .lo_rdata(8'h00), .hi_rdata(8'h00), .attr_rdata(8'h00),
    .narrow(steer_w.narrow), .host_d_in(host_d_in),
    .host_d_out(unused_d), .wd_lo(wd_lo_w), .wd_hi(wd_hi_w)
  );

  logic [7:0] rd_wd_lo_unused, rd_wd_hi_unused;

  lsteer_data_route u_rd_route (
    .src_lo(steer_q.src_lo), .src_hi(steer_q.src_hi),
    .drv_lo(steer_q.drv_lo), .drv_hi(steer_q.drv_hi),
    .lo_rdata(lo_rdata), .hi_rdata(hi_rdata), .attr_rdata(attr_rdata),
    .narrow(1'b0), .host_d_in(16'h0000),
    .host_d_out(host_d_out), .wd_lo(rd_wd_lo_unused), .wd_hi(rd_wd_hi_unused)
  );

  // next state
  always_comb begin
    steer_d = steer_w;
    dev_any = steer_w.lo_rd | steer_w.lo_wr | steer_w.hi_rd | steer_w.hi_wr;
    cs_n_d  = ~(hit_w & {NUM_PAIRS{dev_any}});
    addr_d  = steer_w.xfer ? host_addr[PAIR_LOG2-1:1] : addr_q;
    wd_lo_d = steer_w.wr_cyc ? wd_lo_w : wd_lo_q;
    wd_hi_d = steer_w.wr_cyc ? wd_hi_w : wd_hi_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steer_q <= STEER_IDLE;
      cs_n_q  <= '1;
      addr_q  <= '0;
      wd_lo_q <= '0;
      wd_hi_q <= '0;
    end else begin
      steer_q <= steer_d;
      cs_n_q  <= cs_n_d;
      addr_q  <= addr_d;
      wd_lo_q <= wd_lo_d;
      wd_hi_q <= wd_hi_d;
    end
  end

  assign host_oe_lo = steer_q.drv_lo;
  assign host_oe_hi = steer_q.drv_hi;
  assign pair_cs_n  = cs_n_q;
  assign dev_addr   = addr_q;
  assign lo_rden_n  = ~steer_q.lo_rd;
  assign lo_wren_n  = ~steer_q.lo_wr;
  assign hi_rden_n  = ~steer_q.hi_rd;
  assign hi_wren_n  = ~steer_q.hi_wr;
  assign lo_wdata   = wd_lo_q;
  assign hi_wdata   = wd_hi_q;
  assign attr_sel_n = ~steer_q.attr;

  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pair_cs_n));

  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> (lo_wren_n && hi_wren_n));

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_even_n && en_odd_n) |=> (!host_oe_lo && !host_oe_hi && lo_rden_n &&
      hi_rden_n && lo_wren_n && hi_wren_n && attr_sel_n && (&pair_cs_n)));

  assert_strobe_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb_n == wr_strb_n) |=> (lo_rden_n && hi_rden_n && lo_wren_n &&
      hi_wren_n && attr_sel_n && !host_oe_lo && !host_oe_hi));

  assert_lane_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((!lo_rden_n && !lo_wren_n) || (!hi_rden_n && !hi_wren_n)));

  assert_attr_hi_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!attr_space_n && !en_odd_n && !rd_strb_n && wr_strb_n) |=>
      (host_d_out[15:8] == 8'hFF));

  assert_attr_no_flash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_space_n |=> ((&pair_cs_n) && lo_rden_n && hi_rden_n));

endmodule

// File: tb/lane_steer_tb.sv
`timescale 1ns/1ps
module lane_steer_tb;

  localparam int AW = 12;
  localparam int PL = 8;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] host_addr;
  logic en_even_n, en_odd_n, rd_strb_n, wr_strb_n, attr_space_n, wr_lock;
  logic [15:0] host_d_in, host_d_out;
  logic host_oe_lo, host_oe_hi;
  logic [NP-1:0] pair_cs_n;
  logic [PL-2:0] dev_addr;
  logic lo_rden_n, lo_wren_n, hi_rden_n, hi_wren_n, attr_sel_n;
  logic [7:0] lo_wdata, hi_wdata, lo_rdata, hi_rdata, attr_rdata;

  always #10 clk = ~clk;

  lane_steer #(.ADDR_W(AW), .PAIR_LOG2(PL), .NUM_PAIRS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
    .en_even_n(en_even_n), .en_odd_n(en_odd_n),
    .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
    .attr_space_n(attr_space_n), .wr_lock(wr_lock),
    .host_d_in(host_d_in), .host_d_out(host_d_out),
    .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi),
    .pair_cs_n(pair_cs_n), .dev_addr(dev_addr),
    .lo_rden_n(lo_rden_n), .lo_wren_n(lo_wren_n),
    .hi_rden_n(hi_rden_n), .hi_wren_n(hi_wren_n),
    .lo_wdata(lo_wdata), .hi_wdata(hi_wdata),
    .lo_rdata(lo_rdata), .hi_rdata(hi_rdata),
    .attr_sel_n(attr_sel_n), .attr_rdata(attr_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected state (bench encoding: lane source 0 low dev, 1 high dev, 2 attr, 3 FF)
  logic [NP-1:0] e_cs;
  logic e_lr, e_lw, e_hr, e_hw, e_as, e_ol, e_oh;
  int e_sl, e_sh;
  logic [PL-2:0] e_da;
  logic [7:0] e_wl, e_wh;
  string e_tag;

  function automatic logic [7:0] lane_val(int s);
    if (s == 0) return lo_rdata;
    if (s == 1) return hi_rdata;
    if (s == 2) return attr_rdata;
    return 8'hFF;
  endfunction

  task automatic check();
    logic [7:0] xl, xh;
    logic ok;
    ok = 1'b1;
    xl = lane_val(e_sl);
    xh = lane_val(e_sh);
    if (pair_cs_n !== e_cs || lo_rden_n !== e_lr || lo_wren_n !== e_lw ||
        hi_rden_n !== e_hr || hi_wren_n !== e_hw || attr_sel_n !== e_as ||
        host_oe_lo !== e_ol || host_oe_hi !== e_oh || dev_addr !== e_da) ok = 1'b0;
    if (e_ol && host_d_out[7:0] !== xl) ok = 1'b0;
    if (e_oh && host_d_out[15:8] !== xh) ok = 1'b0;
    if (!e_lw && lo_wdata !== e_wl) ok = 1'b0;
    if (!e_hw && hi_wdata !== e_wh) ok = 1'b0;
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got cs=%b en=%b%b%b%b as=%b oe=%b%b d=%h da=%h w=%h/%h exp cs=%b en=%b%b%b%b as=%b oe=%b%b d=%h%h da=%h w=%h/%h",
        e_tag, pair_cs_n, lo_rden_n, lo_wren_n, hi_rden_n, hi_wren_n, attr_sel_n,
        host_oe_lo, host_oe_hi, host_d_out, dev_addr, lo_wdata, hi_wdata,
        e_cs, e_lr, e_lw, e_hr, e_hw, e_as, e_ol, e_oh, xh, xl, e_da, e_wl, e_wh);
    end
  endtask

  task automatic model();
    bit acc, rd, wr, word, nar, odd, wl, wh, inr, com;
    int pidx;
    acc  = !en_even_n || !en_odd_n;
    rd   = acc && !rd_strb_n && wr_strb_n;
    wr   = acc && !wr_strb_n && rd_strb_n;
    word = !en_even_n && !en_odd_n;
    nar  = !en_even_n && en_odd_n;
    odd  = en_even_n && !en_odd_n;
    wl   = word || (nar && !host_addr[0]);
    wh   = word || (nar && host_addr[0]) || odd;
    pidx = int'(host_addr >> PL);
    inr  = pidx < NP;
    com  = attr_space_n;
    e_lr = !(rd && com && inr && wl);
    e_hr = !(rd && com && inr && wh);
    e_lw = !(wr && com && inr && wl && !wr_lock);
    e_hw = !(wr && com && inr && wh && !wr_lock);
    e_cs = '1;
    if (!(e_lr && e_hr && e_lw && e_hw)) e_cs[pidx] = 1'b0;
    e_as = !(!com && (rd || wr));
    e_ol = rd && !en_even_n;
    e_oh = rd && !en_odd_n;
    if (!com) begin
      e_sl = (nar && host_addr[0]) ? 3 : 2;
      e_sh = 3;
    end else if (!inr) begin
      e_sl = 3; e_sh = 3;
    end else begin
      e_sl = (nar && host_addr[0]) ? 1 : 0;
      e_sh = 1;
    end
    if (rd || wr) e_da = host_addr[PL-1:1];
    if (wr) begin
      e_wl = host_d_in[7:0];
      e_wh = nar ? host_d_in[7:0] : host_d_in[15:8];
    end
  endtask

  // ev/od: lane enables; o/w: strobes; g: attribute space; p: lock
  task automatic step(input logic [AW-1:0] a, input logic ev, od, o, w, g, p,
                      input logic [15:0] din, input string tag);
    @(negedge clk);
    check();
    host_addr = a; en_even_n = ev; en_odd_n = od; rd_strb_n = o; wr_strb_n = w;
    attr_space_n = g; wr_lock = p; host_d_in = din;
    lo_rdata = 8'(n_vec * 7 + 8'h11);
    hi_rdata = 8'(n_vec * 13 + 8'h5A);
    attr_rdata = 8'(n_vec * 3 + 8'hC3);
    model();
    e_tag = tag;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_addr = '0; en_even_n = 1'b1; en_odd_n = 1'b1; rd_strb_n = 1'b1;
    wr_strb_n = 1'b1; attr_space_n = 1'b1; wr_lock = 1'b0; host_d_in = '0;
    lo_rdata = 8'h00; hi_rdata = 8'h00; attr_rdata = 8'h00;
    e_cs = '1; e_lr = 1; e_lw = 1; e_hr = 1; e_hw = 1; e_as = 1; e_ol = 0; e_oh = 0;
    e_sl = 3; e_sh = 3; e_da = '0; e_wl = '0; e_wh = '0; e_tag = "R1 reset";
    repeat (3) @(negedge clk);
    check();                       // R1 during reset
    rst_n = 1'b1;
    // R1 first cycle after reset: idle inputs keep reset values
    step(12'h000, 1, 1, 1, 1, 1, 0, 16'h0000, "R1 post-reset");
    // R2 standby with strobes active
    step(12'h012, 1, 1, 0, 1, 1, 0, 16'h0000, "R2 standby read");
    step(12'h013, 1, 1, 1, 0, 0, 0, 16'hABCD, "R2 standby write");
    // R3 word reads, A0 both values, several pairs
    step(12'h024, 0, 0, 0, 1, 1, 0, 16'h0000, "R3 word read pair0");
    step(12'h125, 0, 0, 0, 1, 1, 0, 16'h0000, "R3 word read a0=1 pair1");
    step(12'h2FE, 0, 0, 0, 1, 1, 0, 16'h0000, "R3 word read pair2");
    // R4 byte reads
    step(12'h040, 0, 1, 0, 1, 1, 0, 16'h0000, "R4 byte read even");
    step(12'h141, 0, 1, 0, 1, 1, 0, 16'h0000, "R4 byte read odd swap");
    // R5 odd-only read
    step(12'h262, 1, 0, 0, 1, 1, 0, 16'h0000, "R5 odd-only read");
    // R6 writes
    step(12'h070, 0, 0, 1, 0, 1, 0, 16'hA55A, "R6 word write");
    step(12'h171, 0, 1, 1, 0, 1, 0, 16'h3C96, "R6 byte write odd");
    step(12'h072, 0, 1, 1, 0, 1, 0, 16'h1234, "R6 byte write even");
    step(12'h273, 1, 0, 1, 0, 1, 0, 16'hBEEF, "R6 odd-only write");
    // R7 write lock
    step(12'h080, 0, 0, 1, 0, 1, 1, 16'hFACE, "R7 locked word write");
    step(12'h081, 0, 0, 1, 0, 0, 1, 16'hFACE, "R7 locked attr write");
    step(12'h082, 0, 0, 0, 1, 1, 1, 16'h0000, "R7 read under lock");
    // R8 strobe clash and idle strobes
    step(12'h090, 0, 0, 0, 0, 1, 0, 16'h1111, "R8 both strobes low");
    step(12'h091, 0, 0, 1, 1, 1, 0, 16'h2222, "R8 both strobes high");
    // R9 beyond populated pairs
    step(12'h300, 0, 0, 0, 1, 1, 0, 16'h0000, "R9 out-of-range read");
    step(12'hF41, 0, 1, 1, 0, 1, 0, 16'h7777, "R9 out-of-range write");
    // R10 attribute space
    step(12'h0A0, 0, 0, 0, 1, 0, 0, 16'h0000, "R10 attr word read");
    step(12'h0A2, 0, 1, 0, 1, 0, 0, 16'h0000, "R10 attr byte even");
    step(12'h0A3, 0, 1, 0, 1, 0, 0, 16'h0000, "R10 attr byte odd");
    step(12'h0A4, 1, 0, 0, 1, 0, 0, 16'h0000, "R10 attr odd-only");
    // R12 address hold across idle, then reload
    step(12'h1B6, 1, 1, 1, 1, 1, 0, 16'h0000, "R12 hold idle");
    step(12'h1B8, 0, 0, 0, 1, 1, 0, 16'h0000, "R12 reload");
    // R11 random mix, compared every clock
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(AW'($urandom), r[0], r[1], r[2], r[3], r[4] | r[5], r[6] & r[7],
           16'($urandom), "R11 random");
    end
    @(negedge clk);
    check();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule